// File: doc/BRIEF.md
# I2C Register Port with Coherent Time Snapshot

This block is the serial front end of a timekeeping core. It acts as an I2C target at one fixed 7-bit address and opens a 17-byte register space (0x00 to 0x10) to the bus master. SCL and SDA reach it as samples already synchronised to the system clock. Its only bus output is an enable for the SDA pull-down. Toward the core it offers a registered write strobe with address and data, and a read address with a read-data return.

A pointer names the register being accessed. The first data byte of a write loads the pointer. Each byte written or read then moves the pointer up by one, and after 0x10 it returns to 0x00. The seven time bytes (0x00 to 0x06) are never read live. They are copied into a shadow buffer on every START and whenever the pointer steps to 0x00, and reads of those addresses return the copy. A power-fail input keeps the block off the bus. A watchdog on SCL-low time, counted in millisecond ticks derived from a 32.768 kHz enable, returns the port to idle.

Top module: `i2c_reg_port`

## Requirements
- R1: While reset is applied and in the first cycle after it, the SDA pull-down is off and no register write is issued.
- R2: Only address bytes 0xD0 (write) and 0xD1 (read) are acknowledged by pulling SDA low during the ninth clock. After any other address the SDA pull-down stays off until the next START.
- R3: In a write, the byte after the address byte loads the pointer. A pointer byte above 0x10 loads 0x00. Every later byte is acknowledged and written to the pointer address as a single-cycle strobe, issued once the SCL falling edge that opens the ACK bit has been seen. The pointer then increments. Data bits are sampled on SCL rising edges.
- R4: The pointer steps from 0x10 to 0x00, on both write and read increments.
- R5: A read with no pointer byte starts at the current pointer. A write that carries only a pointer byte, followed by a repeated START and a read, starts at the loaded pointer. Each byte sent moves the pointer by one.
- R6: Reads of 0x00 to 0x06 return the time value captured at the latest START, or at the latest pointer step to 0x00, whichever came later. Changes to the live time after that capture are not seen.
- R7: Read bits are sent MSB first. Each bit appears after an SCL falling edge, and the pull-down is released for the master's acknowledge bit. A NACK (SDA high on the ninth rising edge) ends the read, and the pull-down stays off until the next START.
- R8: The pull-down is only switched on after an SCL falling edge, never while SCL is high, and SCL is never driven.
- R9: When SCL stays low for TIMEOUT_MS millisecond ticks (one tick every TICK_DIV enables of the 32.768 kHz input), the port releases SDA and ignores the bus until a new START.
- R10: While the power-fail input is high, the port does not acknowledge its address or any byte, and it issues no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired bus level) |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| pwr_fail | input | 1 | High while supply is below the power-fail threshold |
| live_time | input | TIME_REGS*8 | Live time bytes, byte i at bits [8i+7:8i] |
| sda_pd | output | 1 | SDA pull-down enable |
| reg_raddr | output | AW | Read address to the core (current pointer) |
| reg_rdata | input | 8 | Core read data for reg_raddr |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_waddr | output | AW | Write address |
| reg_wdata | output | 8 | Write data |

## Verification
The bench keeps the default address, the 17-byte space and the seven time bytes, so pointer wraps and captures at 0x00 are exercised at their real boundaries. It shrinks the watchdog to TICK_DIV=4 and TIMEOUT_MS=3, which brings an SCL-low timeout within about a hundred clocks. A timeout can therefore be hit during a read in which the port is driving SDA. A behavioural model of the core and an expected-write queue are compared on every clock, so a stray, missing or misaddressed write strobe is caught in the cycle it appears.

// File: rtl/i2c_rp_pkg.sv
// Shared types for the I2C register port.
package i2c_rp_pkg;
    // Port sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_TX,
        ST_SKIP
    } port_state_t;

    // Meaning of the byte being received.
    typedef enum logic [1:0] {
        RX_ADDR,
        RX_PTR,
        RX_DATA
    } rx_kind_t;
endpackage

// File: rtl/i2c_rp_line_events.sv
// Detects SCL edges and START/STOP conditions from synchronised samples.
// Assumes scl_i/sda_i are already free of metastability.
module i2c_rp_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_low
);
    logic scl_q;
    logic sda_q;

    // Keep the previous sample of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and conditions from the sample pair.
    always_comb begin
        scl_rise = scl_i & ~scl_q;
        scl_fall = ~scl_i & scl_q;
        start_ev = scl_i & scl_q & sda_q & ~sda_i;
        stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
        scl_low  = ~scl_q;
    end
endmodule

// File: rtl/i2c_rp_timeout.sv
// SCL-low watchdog: derives a millisecond tick from the 32.768 kHz enable
// and pulses expire once SCL has been low for TIMEOUT_MS ticks.
// Assumes tick_32k is a one-cycle enable.
module i2c_rp_timeout #(
    parameter int TICK_DIV   = 33,
    parameter int TIMEOUT_MS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_32k,
    input  logic scl_low,
    output logic expire
);
    localparam int PW = $clog2(TICK_DIV);
    localparam int CW = $clog2(TIMEOUT_MS + 1);

    logic [PW-1:0] pre_cnt;
    logic [CW-1:0] low_ms;
    logic          ms_tick;

    assign ms_tick = tick_32k && (pre_cnt == PW'(TICK_DIV - 1));
    assign expire  = ms_tick && scl_low && (low_ms == CW'(TIMEOUT_MS - 1));

    // Free-running prescaler from 32.768 kHz enables to millisecond ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_cnt <= '0;
        else if (ms_tick)  pre_cnt <= '0;
        else if (tick_32k) pre_cnt <= pre_cnt + 1'b1;
    end

    // Count whole ticks while SCL stays low; saturate after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !scl_low)                         low_ms <= '0;
        else if (ms_tick && low_ms < CW'(TIMEOUT_MS))   low_ms <= low_ms + 1'b1;
    end
endmodule

// File: rtl/i2c_rp_snapshot.sv
// Shadow buffer for the time bytes: captures all of them at once and
// serves reads from the copy. Assumes rd_idx < NREGS when its result is used.
module i2c_rp_snapshot #(
    parameter int NREGS = 7,
    parameter int AW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [NREGS*8-1:0] live,
    input  logic [AW-1:0]     rd_idx,
    output logic [7:0]        rd_byte
);
    logic [7:0] shadow [NREGS];

    // Copy every live byte in the same cycle on a capture request.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n)       shadow[i] <= '0;
            else if (capture) shadow[i] <= live[i*8 +: 8];
        end
    end

    // Select the addressed shadow byte.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NREGS; i++)
            if (rd_idx == AW'(i)) rd_byte = shadow[i];
    end
endmodule

// File: rtl/i2c_reg_port.sv
// I2C target giving bus access to a small register space with an
// auto-incrementing, wrapping pointer and a coherent copy of the time bytes.
// Assumes synchronised SCL/SDA inputs and a 32.768 kHz enable; never drives SCL.
module i2c_reg_port
    import i2c_rp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h68,
    parameter int         LAST_REG   = 16,
    parameter int         TIME_REGS  = 7,
    parameter int         TICK_DIV   = 33,
    parameter int         TIMEOUT_MS = 30,
    localparam int        AW         = $clog2(LAST_REG + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   tick_32k,
    input  logic                   pwr_fail,
    input  logic [TIME_REGS*8-1:0] live_time,
    output logic                   sda_pd,
    output logic [AW-1:0]          reg_raddr,
    input  logic [7:0]             reg_rdata,
    output logic                   reg_we,
    output logic [AW-1:0]          reg_waddr,
    output logic [7:0]             reg_wdata
);
    localparam logic [AW-1:0] LAST = AW'(LAST_REG);

    logic scl_rise, scl_fall, start_ev, stop_ev, scl_low, tmo_expire;
    port_state_t  state;
    rx_kind_t     kind;
    logic [3:0]   bit_cnt;
    logic [7:0]   shreg, tx_sh, snap_byte, rd_byte;
    logic         ack_on, tx_on, rw, nack;
    logic [AW-1:0] ptr, ptr_next;
    logic         ptr_load, commit, tx_load, ptr_inc, snap_cap;

    i2c_rp_line_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
        .stop_ev(stop_ev), .scl_low(scl_low)
    );

    i2c_rp_timeout #(.TICK_DIV(TICK_DIV), .TIMEOUT_MS(TIMEOUT_MS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .scl_low(scl_low),
        .expire(tmo_expire)
    );

    i2c_rp_snapshot #(.NREGS(TIME_REGS), .AW(AW)) u_snap (
        .clk(clk), .rst_n(rst_n), .capture(snap_cap), .live(live_time),
        .rd_idx(ptr), .rd_byte(snap_byte)
    );

    // Byte-boundary events that move the pointer or touch the core.
    always_comb begin
        ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
        ptr_load = (state == ST_RX) && (kind == RX_PTR) && scl_fall
                   && (bit_cnt == 4'd8) && !pwr_fail;
        commit   = (state == ST_RX) && (kind == RX_DATA) && scl_fall
                   && (bit_cnt == 4'd8) && !pwr_fail;
        tx_load  = scl_fall && (bit_cnt == 4'd9) && !pwr_fail
                   && (((state == ST_RX) && (kind == RX_ADDR) && rw)
                       || ((state == ST_TX) && !nack));
        ptr_inc  = commit || tx_load;
        snap_cap = start_ev || (ptr_inc && (ptr == LAST));
        rd_byte  = (ptr < AW'(TIME_REGS)) ? snap_byte : reg_rdata;
        reg_raddr = ptr;
        sda_pd   = ack_on || (tx_on && !tx_sh[7]);
    end

    // Register pointer: loaded by the pointer byte, stepped per data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (ptr_load) ptr <= (shreg > 8'(LAST_REG)) ? '0 : shreg[AW-1:0];
        else if (ptr_inc)  ptr <= ptr_next;
    end

    // Registered write strobe toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= commit;
            if (commit) begin
                reg_waddr <= ptr;
                reg_wdata <= shreg;
            end
        end
    end

    // Bus sequencer: bit counting, acknowledge and read-bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; kind <= RX_ADDR; bit_cnt <= '0; shreg <= '0;
            tx_sh <= '1; ack_on <= 1'b0; tx_on <= 1'b0; rw <= 1'b0; nack <= 1'b0;
        end else if (tmo_expire || stop_ev) begin
            state <= ST_IDLE; ack_on <= 1'b0; tx_on <= 1'b0;
        end else if (start_ev) begin
            state <= ST_RX; kind <= RX_ADDR; bit_cnt <= '0;
            ack_on <= 1'b0; tx_on <= 1'b0; rw <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        if (bit_cnt < 4'd8) shreg <= {shreg[6:0], sda_i};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && bit_cnt == 4'd8) begin
                        if (pwr_fail) state <= ST_SKIP;
                        else if (kind != RX_ADDR) ack_on <= 1'b1;
                        else if (shreg[7:1] == DEV_ADDR) begin
                            ack_on <= 1'b1;
                            rw     <= shreg[0];
                        end else state <= ST_SKIP;
                    end
                    if (scl_fall && bit_cnt == 4'd9) begin
                        ack_on  <= 1'b0;
                        bit_cnt <= '0;
                        if (kind == RX_ADDR && rw) begin
                            state <= tx_load ? ST_TX : ST_SKIP;
                            tx_sh <= rd_byte;
                            tx_on <= tx_load;
                        end else if (kind == RX_ADDR) kind <= RX_PTR;
                        else kind <= RX_DATA;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        if (bit_cnt == 4'd8) nack <= sda_i;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall) begin
                        if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) tx_sh <= {tx_sh[6:0], 1'b1};
                        if (bit_cnt == 4'd8) tx_on <= 1'b0;
                        if (bit_cnt == 4'd9) begin
                            bit_cnt <= '0;
                            if (tx_load) begin
                                tx_sh <= rd_byte;
                                tx_on <= 1'b1;
                            end else state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_reg_port_chk.sv
// Property checker for i2c_reg_port, attached by bind below.
module i2c_reg_port_chk #(
    parameter int AW       = 5,
    parameter int LAST_REG = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          pwr_fail,
    input logic          sda_pd,
    input logic          reg_we,
    input logic [AW-1:0] ptr,
    input logic          ptr_inc,
    input logic          tmo_expire
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!sda_pd && !reg_we));

    // R3
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ptr_inc) && $past(ptr) == AW'(LAST_REG)) |-> (ptr == '0));

    // R8
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pd) |-> !$past(scl_i));

    // R9
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expire |=> !sda_pd);

    // R10
    pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_fail) |-> !reg_we);
endmodule

bind i2c_reg_port i2c_reg_port_chk #(.AW(AW), .LAST_REG(LAST_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .pwr_fail(pwr_fail),
    .sda_pd(sda_pd), .reg_we(reg_we), .ptr(ptr), .ptr_inc(ptr_inc),
    .tmo_expire(tmo_expire)
);

// File: tb/i2c_reg_port_bench.sv
module i2c_reg_port_bench;
    localparam int AW = 5;
    localparam int H  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic tick_32k = 1'b0, pwr_fail = 1'b0;
    logic [55:0] live_time = '0;
    logic sda_pd, reg_we;
    logic [AW-1:0] reg_raddr, reg_waddr;
    logic [7:0] reg_rdata, reg_wdata;
    wire sda_line = sda_m & ~sda_pd;

    int checks = 0, fails = 0;
    logic [7:0] core_mem [17];
    logic [7:0] exp_mem  [17];
    logic [12:0] wq [$];

    always #5 clk = ~clk;

    i2c_reg_port #(.TICK_DIV(4), .TIMEOUT_MS(3)) u_i2c_reg_port (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .tick_32k(tick_32k), .pwr_fail(pwr_fail), .live_time(live_time),
        .sda_pd(sda_pd), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
    );

    // Behavioural core register file.
    assign reg_rdata = (reg_raddr <= 5'd16) ? core_mem[reg_raddr] : 8'h00;
    always @(posedge clk) if (reg_we && reg_waddr <= 5'd16) core_mem[reg_waddr] <= reg_wdata;

    // 32.768 kHz enable model: one pulse every 8 clocks.
    initial forever begin
        repeat (7) @(negedge clk);
        tick_32k = 1'b1;
        @(negedge clk);
        tick_32k = 1'b0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every-clock comparison of write strobes against the expected queue (R3, R10).
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (wq.size() == 0) check(1'b0, "R10 unexpected write", {reg_waddr, reg_wdata}, 0);
            else begin
                logic [12:0] e;
                e = wq.pop_front();
                check({reg_waddr, reg_wdata} == e, "R3 write addr/data", {reg_waddr, reg_wdata}, e);
            end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; waitc(H); scl_m = 1'b1; waitc(H);
        sda_m = 1'b0; waitc(H); scl_m = 1'b0; waitc(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; waitc(H); scl_m = 1'b1; waitc(H); sda_m = 1'b1; waitc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitc(H); scl_m = 1'b1; waitc(H); scl_m = 1'b0;
        end
        waitc(H); sda_m = 1'b1; scl_m = 1'b1; waitc(H);
        ack = sda_line; scl_m = 1'b0; waitc(H);
    endtask

    task automatic recv_byte(input logic master_nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b1; waitc(H); b[i] = sda_line; scl_m = 1'b0; waitc(H);
        end
        sda_m = master_nack; scl_m = 1'b1; waitc(H); scl_m = 1'b0; waitc(H);
        sda_m = 1'b1;
    endtask

    task automatic wr_exp(input int a, input logic [7:0] d);
        wq.push_back({5'(a), d});
        exp_mem[a] = d;
    endtask

    function automatic logic [55:0] pack_live(input logic [7:0] base);
        logic [55:0] v;
        for (int i = 0; i < 7; i++) v[i*8 +: 8] = base + 8'(i);
        return v;
    endfunction

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 17; i++) begin
            core_mem[i] = 8'(i * 7 + 3);
            exp_mem[i]  = 8'(i * 7 + 3);
        end
        waitc(5);
        check(sda_pd == 1'b0, "R1 sda_pd in reset", sda_pd, 0);
        check(reg_we == 1'b0, "R1 reg_we in reset", reg_we, 0);
        rst_n = 1'b1;
        waitc(1);
        check(sda_pd == 1'b0, "R1 sda_pd after reset", sda_pd, 0);

        // Write with pointer 0x0E, running across the wrap (R3, R4).
        i2c_start();
        send_byte(8'hD0, a); check(a == 1'b0, "R2 ack 0xD0", a, 0);
        send_byte(8'h0E, a); check(a == 1'b0, "R3 ack pointer", a, 0);
        wr_exp(14, 8'hA5); send_byte(8'hA5, a); check(a == 1'b0, "R3 ack data", a, 0);
        wr_exp(15, 8'h3C); send_byte(8'h3C, a);
        wr_exp(16, 8'h77); send_byte(8'h77, a);
        wr_exp(0, 8'h12);  send_byte(8'h12, a); check(a == 1'b0, "R4 ack after wrap", a, 0);
        i2c_stop();
        check(wq.size() == 0, "R4 all writes seen", wq.size(), 0);

        // Foreign address is ignored (R2).
        i2c_start();
        send_byte(8'hA0, a); check(a == 1'b1, "R2 no ack foreign", a, 1);
        send_byte(8'h00, a); check(a == 1'b1, "R2 silent until START", a, 1);
        i2c_stop();

        // Dummy write + repeated START read (R5).
        i2c_start(); send_byte(8'hD0, a); send_byte(8'h08, a);
        i2c_start(); send_byte(8'hD1, a); check(a == 1'b0, "R2 ack 0xD1", a, 0);
        recv_byte(1'b0, d); check(d == exp_mem[8],  "R5 read 0x08", d, exp_mem[8]);
        recv_byte(1'b0, d); check(d == exp_mem[9],  "R5 read 0x09", d, exp_mem[9]);
        recv_byte(1'b1, d); check(d == exp_mem[10], "R7 read 0x0A then NACK", d, exp_mem[10]);
        i2c_stop();

        // Read from current pointer (R5).
        i2c_start(); send_byte(8'hD1, a);
        recv_byte(1'b1, d); check(d == exp_mem[11], "R5 current pointer read", d, exp_mem[11]);
        i2c_stop();

        // Snapshot at START (R6) and release after NACK (R7).
        live_time = pack_live(8'h20);
        i2c_start(); send_byte(8'hD0, a); send_byte(8'h00, a);
        i2c_start(); live_time = pack_live(8'h40);
        send_byte(8'hD1, a);
        recv_byte(1'b0, d); check(d == 8'h20, "R6 snapshot byte 0", d, 8'h20);
        recv_byte(1'b1, d); check(d == 8'h21, "R6 snapshot byte 1", d, 8'h21);
        recv_byte(1'b1, d); check(d == 8'hFF, "R7 released after NACK", d, 8'hFF);
        i2c_stop();

        // Snapshot at pointer wrap during read (R4, R6).
        i2c_start(); send_byte(8'hD0, a); send_byte(8'h10, a);
        i2c_start(); live_time = pack_live(8'h60);
        send_byte(8'hD1, a);
        recv_byte(1'b0, d); check(d == exp_mem[16], "R4 read 0x10", d, exp_mem[16]);
        recv_byte(1'b1, d); check(d == 8'h60, "R6 wrap snapshot", d, 8'h60);
        i2c_stop();

        // Power fail blocks access (R10).
        pwr_fail = 1'b1;
        i2c_start();
        send_byte(8'hD0, a); check(a == 1'b1, "R10 no ack in power fail", a, 1);
        send_byte(8'h05, a); check(a == 1'b1, "R10 byte not acked", a, 1);
        i2c_stop();
        i2c_start();
        send_byte(8'hD1, a); check(a == 1'b1, "R10 read not acked", a, 1);
        i2c_stop();
        pwr_fail = 1'b0;

        // SCL-low timeout while driving a read bit (R9).
        i2c_start(); send_byte(8'hD0, a); send_byte(8'h0A, a);
        i2c_start(); send_byte(8'hD1, a);
        check(sda_pd == 1'b1, "R7 drives MSB 0 of 0x49", sda_pd, 1);
        waitc(200);
        check(sda_pd == 1'b0, "R9 released after timeout", sda_pd, 0);
        send_byte(8'hD0, a); check(a == 1'b1, "R9 ignored until START", a, 1);
        i2c_stop();
        i2c_start(); send_byte(8'hD1, a); check(a == 1'b0, "R9 recovers on START", a, 0);
        recv_byte(1'b1, d); check(d == exp_mem[11], "R5 pointer after timeout", d, exp_mem[11]);
        i2c_stop();

        waitc(4);
        check(wq.size() == 0, "R3 no missing writes", wq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule